// File: doc/BRIEF.md
# Programmable LED Activity Combiner

This block drives one active-high LED output from a chosen set of network activity events: transmit, receive, collision, jabber and correct twisted-pair receive polarity. A 16-bit control/status register holds one enable bit for each event. The LED shows the logical OR of every enabled event. A qualifier bit can limit receive indication to frames that hit the station address filter. An optional shared pulse stretcher keeps the LED lit for a parameterised number of clock cycles after the last qualifying event, so that single-cycle events stay visible.

Software writes the register through a plain write-enable and 16-bit data port, and reads it back at any time on a separate read-data bus. The top bit of the read value shows the raw combined event state before stretching. The event inputs are synchronous to the block clock and may be single-cycle pulses or levels. This block has no streaming data path, so every pin is a plain control or status signal. Reset is synchronous and active high.

Top module: `led_activity_combiner`

## Requirements
- R1: After reset the read value is 0x0090: transmit is enabled, stretching is on, and every other bit is clear. The LED is low.
- R2: Read bits 14:8 and bit 6 are always zero. A write stores only bits 7 and 5:0. The write data for bit 15 and for the reserved bits is ignored.
- R3: The enables sit at these bit positions: bit 4 transmit, bit 3 receive polarity, bit 2 receive, bit 1 jabber, bit 0 collision. The combined value is the OR of every event whose enable is set, and several enables may be set at once.
- R4: When bit 5 (address qualify) is set, a receive event counts only in a cycle where the address-hit input is also high. When bit 5 is clear, address hit has no effect.
- R5: When bit 7 (stretch enable) is clear, the LED equals the combined value of the previous cycle. The LED is registered, so it has one cycle of latency.
- R6: When bit 7 is set, a qualifying event raises the LED on the next edge. The LED then stays high for exactly STRETCH_CYCLES cycles after the last cycle that had a qualifying event. A new event during the hold restarts the count.
- R7: Read bit 15 is the unstretched combined value registered on the previous edge. It never shows stretching.
- R8: An event whose enable bit is clear has no effect on the LED or on read bit 15.
- R9: A write changes the enables that the combiner uses from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read data, with raw status in bit 15 |
| ev_tx | input | 1 | Transmit activity event |
| ev_rx | input | 1 | Receive activity event |
| ev_rx_addr_hit | input | 1 | Current receive frame matched the address filter |
| ev_col | input | 1 | Collision event |
| ev_jab | input | 1 | Jabber event |
| ev_pol_ok | input | 1 | Receive polarity is correct |
| led | output | 1 | Registered LED drive, active high |

## Verification
The bench goes after the exact end of the stretch window. A counter that is off by one would drop the LED a cycle early or late. It also retriggers during a hold, and a design that fails to reload the counter would go dark in the middle of activity. Writes of all ones check that reserved bits and bit 15 never stick. A leak there would show up as a nonzero reserved read or a stuck status bit. Receive events with and without address hit, under qualify on and off, expose a filter that is applied backwards or ignored. Events on disabled sources must leave the LED dark.

// File: rtl/led_comb_pkg.sv
package led_comb_pkg;
  localparam int REG_W    = 16;
  localparam int B_COL    = 0;
  localparam int B_JAB    = 1;
  localparam int B_RX     = 2;
  localparam int B_POL    = 3;
  localparam int B_TX     = 4;
  localparam int B_QUAL   = 5;
  localparam int B_STR    = 7;
  localparam int B_STAT   = 15;
  localparam logic [REG_W-1:0] WR_MASK   = 16'h00BF;
  localparam logic [REG_W-1:0] RST_VALUE = 16'h0090;

  typedef struct packed {
    logic stretch;
    logic qual;
    logic tx;
    logic pol;
    logic rx;
    logic jab;
    logic col;
  } led_ctl_t;
endpackage

// File: rtl/led_ctl_reg.sv
module led_ctl_reg
  import led_comb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             raw_q,
  output led_ctl_t         ctl,
  output logic [REG_W-1:0] rd_data
);
  logic [REG_W-1:0] store_q;

  always_ff @(posedge clk) begin
    if (rst)        store_q <= RST_VALUE;
    else if (wr_en) store_q <= wr_data & WR_MASK;
  end

  always_comb begin
    ctl.stretch = store_q[B_STR];
    ctl.qual    = store_q[B_QUAL];
    ctl.tx      = store_q[B_TX];
    ctl.pol     = store_q[B_POL];
    ctl.rx      = store_q[B_RX];
    ctl.jab     = store_q[B_JAB];
    ctl.col     = store_q[B_COL];
    rd_data         = store_q & WR_MASK;
    rd_data[B_STAT] = raw_q;
  end
endmodule

// File: rtl/led_event_qual.sv
module led_event_qual
  import led_comb_pkg::*;
#(
  parameter int N_EV = 5
) (
  input  led_ctl_t ctl,
  input  logic     ev_tx,
  input  logic     ev_rx,
  input  logic     ev_rx_addr_hit,
  input  logic     ev_col,
  input  logic     ev_jab,
  input  logic     ev_pol_ok,
  output logic     raw
);
  logic [N_EV-1:0] ev_vec;
  logic [N_EV-1:0] en_vec;
  logic [N_EV-1:0] hit_vec;
  logic            rx_ok;

  assign rx_ok  = ev_rx & (~ctl.qual | ev_rx_addr_hit);
  assign ev_vec = {ev_tx, ev_pol_ok, rx_ok, ev_jab, ev_col};
  assign en_vec = {ctl.tx, ctl.pol, ctl.rx, ctl.jab, ctl.col};

  for (genvar i = 0; i < N_EV; i++) begin : g_gate
    assign hit_vec[i] = ev_vec[i] & en_vec[i];
  end

  assign raw = |hit_vec;
endmodule

// File: rtl/led_stretch.sv
module led_stretch #(
  parameter int STRETCH_CYCLES = 1 << 20
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic raw,
  output logic led
);
  localparam int CNT_W = $clog2(STRETCH_CYCLES + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(STRETCH_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      led   <= 1'b0;
    end else if (!enable) begin
      cnt_q <= '0;
      led   <= raw;
    end else if (raw) begin
      cnt_q <= RELOAD;
      led   <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      led   <= 1'b1;
    end else begin
      led   <= 1'b0;
    end
  end
endmodule

// File: rtl/led_activity_combiner.sv
module led_activity_combiner
  import led_comb_pkg::*;
#(
  parameter int STRETCH_CYCLES = 1 << 20
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  input  logic        ev_tx,
  input  logic        ev_rx,
  input  logic        ev_rx_addr_hit,
  input  logic        ev_col,
  input  logic        ev_jab,
  input  logic        ev_pol_ok,
  output logic        led
);
  led_ctl_t ctl;
  logic     raw;
  logic     raw_q;

  always_ff @(posedge clk) begin
    if (rst) raw_q <= 1'b0;
    else     raw_q <= raw;
  end

  led_ctl_reg u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .raw_q(raw_q), .ctl(ctl), .rd_data(rd_data)
  );

  led_event_qual #(.N_EV(5)) u_qual (
    .ctl(ctl), .ev_tx(ev_tx), .ev_rx(ev_rx), .ev_rx_addr_hit(ev_rx_addr_hit),
    .ev_col(ev_col), .ev_jab(ev_jab), .ev_pol_ok(ev_pol_ok), .raw(raw)
  );

  led_stretch #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_str (
    .clk(clk), .rst(rst), .enable(ctl.stretch), .raw(raw), .led(led)
  );
endmodule

// File: rtl/led_activity_combiner_chk.sv
module led_activity_combiner_chk #(
  parameter int STRETCH_CYCLES = 1 << 20
) (
  input logic        clk,
  input logic        rst,
  input logic [15:0] rd_data,
  input logic        led
);
  // R1
  reset_value_chk: assert property (@(posedge clk)
    $fell(rst) |-> (rd_data[14:0] == 15'h0090) && !led);

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data[14:8] == 7'd0) && !rd_data[6]);

  // R5
  direct_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_data[7]) |-> (led == rd_data[15]));

  // R7
  status_implies_led_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[15] |-> led);

  if (STRETCH_CYCLES > 1) begin : g_hold
    // R6
    stretch_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_data[7] && rd_data[15]) |=> led);
  end
endmodule

bind led_activity_combiner led_activity_combiner_chk #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .rd_data(rd_data), .led(led)
);

// File: tb/led_activity_combiner_tb.sv
`timescale 1ns/1ps
module led_activity_combiner_tb;
  localparam int S = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic ev_tx = 0, ev_rx = 0, ev_rx_addr_hit = 0, ev_col = 0, ev_jab = 0, ev_pol_ok = 0;
  logic led;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  logic [15:0] m_ctl;
  logic        m_rawq, m_led;
  int          m_cnt;

  always #4 clk = ~clk;

  led_activity_combiner #(.STRETCH_CYCLES(S)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ev_tx(ev_tx), .ev_rx(ev_rx), .ev_rx_addr_hit(ev_rx_addr_hit),
    .ev_col(ev_col), .ev_jab(ev_jab), .ev_pol_ok(ev_pol_ok), .led(led)
  );

  function automatic logic exp_raw(logic [15:0] c, logic [5:0] e);
    // e = {tx, rx, hit, col, jab, pol}
    return (c[4] & e[5]) | (c[3] & e[0]) | (c[2] & e[4] & (~c[5] | e[3]))
         | (c[1] & e[1]) | (c[0] & e[2]);
  endfunction

  function automatic logic [15:0] exp_rd();
    return {m_rawq, 7'd0, m_ctl[7], 1'b0, m_ctl[5:0]};
  endfunction

  task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic [5:0] e, bit we, logic [15:0] wd, string tag);
    logic r;
    {ev_tx, ev_rx, ev_rx_addr_hit, ev_col, ev_jab, ev_pol_ok} = e;
    wr_en = we; wr_data = wd;
    @(posedge clk);
    r = exp_raw(m_ctl, e);
    if (m_ctl[7]) begin
      if (r) begin m_led = 1; m_cnt = S - 1; end
      else if (m_cnt > 0) begin m_cnt--; m_led = 1; end
      else m_led = 0;
    end else begin
      m_led = r; m_cnt = 0;
    end
    m_rawq = r;
    if (we) m_ctl = wd & 16'h00BF;
    @(negedge clk);
    check(led == m_led, tag, {15'd0, led}, {15'd0, m_led});
    check(rd_data == exp_rd(), (we ? "R2" : "R7"), rd_data, exp_rd());
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    m_ctl = 16'h0090; m_rawq = 0; m_led = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(rd_data == 16'h0090, "R1", rd_data, 16'h0090);
    check(led == 1'b0, "R1", {15'd0, led}, 16'd0);

    // R2 / R9: all-ones write keeps only the writable bits
    step(6'b0, 1, 16'hFFFF, "R9");
    step(6'b0, 0, 16'h0, "R9");
    check(rd_data == 16'h00BF, "R2", rd_data, 16'h00BF);

    // R4: receive qualified by address hit, no stretch
    step(6'b0, 1, 16'h0024, "R9");
    step(6'b010000, 0, 0, "R4");   // rx without hit
    check(led == 0, "R4", {15'd0, led}, 16'd0);
    step(6'b011000, 0, 0, "R4");   // rx with hit
    step(6'b0, 0, 0, "R4");
    step(6'b0, 1, 16'h0004, "R9"); // qualify off
    step(6'b010000, 0, 0, "R4");
    check(led == 1, "R4", {15'd0, led}, 16'd1);

    // R8 / R3: only transmit enabled
    step(6'b0, 1, 16'h0010, "R9");
    step(6'b010111, 0, 0, "R8");
    check(led == 0 && rd_data[15] == 0, "R8", {rd_data[15], 14'd0, led}, 16'd0);
    step(6'b100000, 0, 0, "R3");
    check(led == 1, "R3", {15'd0, led}, 16'd1);
    step(6'b0, 1, 16'h000B, "R3");  // pol, jab, col together
    step(6'b000001, 0, 0, "R3");
    step(6'b000010, 0, 0, "R3");
    step(6'b000100, 0, 0, "R3");
    step(6'b0, 0, 0, "R5");

    // R6: stretch length and retrigger
    step(6'b0, 1, 16'h009F, "R6");
    step(6'b000001, 0, 0, "R6");
    for (int i = 0; i < S + 2; i++) step(6'b0, 0, 0, "R6");
    step(6'b100000, 0, 0, "R6");
    for (int i = 0; i < 3; i++) step(6'b0, 0, 0, "R6");
    step(6'b000010, 0, 0, "R6");
    for (int i = 0; i < S + 2; i++) step(6'b0, 0, 0, "R6");

    // random phases
    for (int p = 0; p < 40; p++) begin
      logic [15:0] w;
      w = 16'($urandom);
      step(6'b0, 1, w, "R9");
      for (int k = 0; k < 50; k++) begin
        logic [5:0] e;
        for (int b = 0; b < 6; b++) e[b] = ($urandom % 8) == 0;
        e[3] = $urandom % 2;
        step(e, 0, 0, m_ctl[7] ? "R6" : "R5");
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule